// File: doc/BRIEF.md
# Half-Duplex Line Driver Direction Sequencer

This block controls the enable of an external line driver on a half-duplex serial link. Before the first character of a burst, it raises the driver enable. It then waits a programmable number of bit intervals and only after that grants the transmitter permission to start. When the last stop bit of the burst has left the transmitter, it keeps the enable high for a second programmable number of bit intervals and then releases it. Both delays are counted on a one-cycle bit-interval tick supplied by the baud generator. When the link runs at a doubled or quadrupled rate, the tick runs faster and the delays shrink with it.

An 8-bit delay configuration holds the two counts as nibbles. The setup count sits in bits 7:4 and the hold count in bits 3:0. The burst window (transmitting plus hold) also drives a receive-blanking output for echo suppression, so echoed characters are masked for as long as the hold count lasts after transmission ends. If automatic direction control is off, the enable simply follows a host-driven level and permission is always granted. The sequencer still tracks bursts with the setup skipped, so blanking stays available in that mode.

The state machine has four states:
- IDLE: no burst.
- SETUP: enable high, waiting out the setup count.
- ACTIVE: enable high, transmitter allowed.
- HOLD: enable high after the last stop bit, waiting out the hold count.

Its transitions are:
- IDLE→SETUP on pending data with a nonzero setup count in automatic mode.
- IDLE→ACTIVE on pending data when the setup count is zero or automatic mode is off.
- SETUP→ACTIVE on the tick that ends the setup count, or at once if automatic mode is cleared.
- ACTIVE→HOLD when the transmitter is idle with nothing pending and the hold count is nonzero.
- ACTIVE→IDLE under the same condition when the hold count is zero.
- HOLD→ACTIVE when new data becomes pending.
- HOLD→IDLE on the tick that ends the hold count.

The transmitter must drop its idle flag no later than the cycle in which it clears pending.

Top module: `hdx_dir_ctrl`

## Requirements
- R1: After reset, with automatic mode on and nothing pending, `rts_out`, `tx_start_ok` and `rx_blank` are all 0.
- R2: With `auto_dir_en` = 0, `tx_start_ok` is 1 at all times and `rts_out` equals `host_rts`.
- R3: In automatic mode with setup count N = `dly_cfg[7:4]` > 0, `rts_out` goes high in the cycle after `tx_pending` is seen in IDLE. `tx_start_ok` stays 0 until the Nth `bit_tick` of the setup, and is 1 in the cycle after that tick.
- R4: With a setup count of 0, `rts_out` and `tx_start_ok` both go high in the cycle after `tx_pending` is seen in IDLE.
- R5: With hold count M = `dly_cfg[3:0]` > 0, the burst ends when the transmitter is idle and nothing is pending. `rts_out` then stays high through the first M-1 ticks, and is 0 in the cycle after the Mth tick.
- R6: With a hold count of 0, `rts_out` is 0 in the cycle after the burst ends.
- R7: If `tx_pending` rises during HOLD, `tx_start_ok` is 1 in the next cycle with no setup ticks, and `rts_out` never drops.
- R8: With `echo_sup_en` = 1, `rx_blank` is 1 while the transmitter is permitted and during the hold count, and 0 in the cycle after the hold count ends. This applies in either direction-control mode.
- R9: With `echo_sup_en` = 0, `rx_blank` stays 0 throughout a burst.
- R10: Ticks that arrive in IDLE or ACTIVE do not shorten a later setup or hold count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per effective bit interval |
| auto_dir_en | input | 1 | Automatic direction control enable |
| echo_sup_en | input | 1 | Echo suppression enable |
| dly_cfg | input | 8 | Setup count [7:4], hold count [3:0] |
| tx_pending | input | 1 | Transmit data waiting |
| tx_idle | input | 1 | Transmitter has no character in flight |
| host_rts | input | 1 | Host-driven enable level used when automatic mode is off |
| rts_out | output | 1 | Line driver enable |
| tx_start_ok | output | 1 | Transmitter may start a character |
| rx_blank | output | 1 | Receive data masked for echo suppression |

## Verification
On every cycle, the assertions check the following:
- a setup or hold state never ends without a tick;
- pending data during the hold always returns the machine straight to ACTIVE;
- ACTIVE never goes back to SETUP;
- permission in automatic mode always comes with the enable high;
- the counter always takes the loaded count.

Exact delay lengths for given nibble values, the way the bypass mode and blanking interact, and the harmlessness of ticks outside the counting states can only be shown by the bench's directed scenarios, which count ticks against the programmed values.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
    localparam int CNT_W = 4;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_HOLD   = 2'd3
    } hdx_state_e;
endpackage

// File: rtl/hdx_bit_counter.sv
module hdx_bit_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    input  logic             bit_tick,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && bit_tick && cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign expire = run && bit_tick && (cnt_q == ONE);

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));  // R3
endmodule

// File: rtl/hdx_dir_fsm.sv
module hdx_dir_fsm
    import hdx_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             auto_dir_en,
    input  logic [CNT_W-1:0] setup_cnt,
    input  logic [CNT_W-1:0] hold_cnt,
    input  logic             tx_pending,
    input  logic             tx_idle,
    output hdx_state_e       state_q
);
    hdx_state_e       state_d;
    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic             cnt_run;
    logic             expire;
    logic             burst_done;

    assign burst_done = tx_idle && !tx_pending;
    assign cnt_run    = (state_q == ST_SETUP) || (state_q == ST_HOLD);

    hdx_bit_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .run      (cnt_run),
        .bit_tick (bit_tick),
        .expire   (expire)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        ld      = 1'b0;
        ld_val  = setup_cnt;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_pending) begin
                    if (auto_dir_en && setup_cnt != '0) begin
                        state_d = ST_SETUP;
                        ld      = 1'b1;
                    end else begin
                        state_d = ST_ACTIVE;
                    end
                end
            end
            ST_SETUP: begin
                if (!auto_dir_en || expire) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (burst_done) begin
                    if (hold_cnt != '0) begin
                        state_d = ST_HOLD;
                        ld      = 1'b1;
                        ld_val  = hold_cnt;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_HOLD: begin
                if (tx_pending)  state_d = ST_ACTIVE;
                else if (expire) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    AST_SETUP_WAITS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETUP && auto_dir_en && !bit_tick) |=> (state_q == ST_SETUP));  // R3
    AST_HOLD_WAITS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !tx_pending && !bit_tick) |=> (state_q == ST_HOLD));  // R5
    AST_HOLD_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && tx_pending) |=> (state_q == ST_ACTIVE));  // R7
    AST_NO_SETUP_AFTER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE) |=> (state_q != ST_SETUP));  // R7
endmodule

// File: rtl/hdx_out_stage.sv
module hdx_out_stage
    import hdx_pkg::*;
(
    input  hdx_state_e state_q,
    input  logic       auto_dir_en,
    input  logic       echo_sup_en,
    input  logic       host_rts,
    output logic       rts_out,
    output logic       tx_start_ok,
    output logic       rx_blank
);
    always_comb begin
        rts_out     = host_rts;
        tx_start_ok = 1'b1;
        rx_blank    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (auto_dir_en) begin
                    rts_out     = 1'b0;
                    tx_start_ok = 1'b0;
                end
            end
            ST_SETUP: begin
                if (auto_dir_en) begin
                    rts_out     = 1'b1;
                    tx_start_ok = 1'b0;
                end
            end
            ST_ACTIVE: begin
                if (auto_dir_en) rts_out = 1'b1;
                rx_blank = echo_sup_en;
            end
            ST_HOLD: begin
                if (auto_dir_en) begin
                    rts_out     = 1'b1;
                    tx_start_ok = 1'b0;
                end
                rx_blank = echo_sup_en;
            end
            default: begin
                rts_out     = 1'b0;
                tx_start_ok = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/hdx_dir_ctrl.sv
module hdx_dir_ctrl
    import hdx_pkg::*;
#(
    parameter int CNT_W = hdx_pkg::CNT_W,
    localparam int CFG_W = 2 * CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             auto_dir_en,
    input  logic             echo_sup_en,
    input  logic [CFG_W-1:0] dly_cfg,
    input  logic             tx_pending,
    input  logic             tx_idle,
    input  logic             host_rts,
    output logic             rts_out,
    output logic             tx_start_ok,
    output logic             rx_blank
);
    hdx_state_e       state_q;
    logic [CNT_W-1:0] setup_cnt;
    logic [CNT_W-1:0] hold_cnt;

    assign setup_cnt = dly_cfg[CFG_W-1:CNT_W];
    assign hold_cnt  = dly_cfg[CNT_W-1:0];

    hdx_dir_fsm #(.CNT_W(CNT_W)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_tick    (bit_tick),
        .auto_dir_en (auto_dir_en),
        .setup_cnt   (setup_cnt),
        .hold_cnt    (hold_cnt),
        .tx_pending  (tx_pending),
        .tx_idle     (tx_idle),
        .state_q     (state_q)
    );

    hdx_out_stage i_out (
        .state_q     (state_q),
        .auto_dir_en (auto_dir_en),
        .echo_sup_en (echo_sup_en),
        .host_rts    (host_rts),
        .rts_out     (rts_out),
        .tx_start_ok (tx_start_ok),
        .rx_blank    (rx_blank)
    );

    AST_GRANT_NEEDS_RTS: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_dir_en && tx_start_ok) |-> rts_out);  // R3
endmodule

// File: tb/test_hdx_dir_ctrl.sv
module test_hdx_dir_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       auto_dir_en = 1'b1;
    logic       echo_sup_en = 1'b0;
    logic [7:0] dly_cfg = 8'h00;
    logic       tx_pending = 1'b0;
    logic       tx_idle = 1'b1;
    logic       host_rts = 1'b0;
    logic       rts_out, tx_start_ok, rx_blank;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hdx_dir_ctrl i_hdx_dir_ctrl (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .auto_dir_en(auto_dir_en),
        .echo_sup_en(echo_sup_en), .dly_cfg(dly_cfg), .tx_pending(tx_pending),
        .tx_idle(tx_idle), .host_rts(host_rts), .rts_out(rts_out),
        .tx_start_ok(tx_start_ok), .rx_blank(rx_blank)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic tick();
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
    endtask

    task automatic start_burst();
        tx_pending = 1'b1;
        tx_idle    = 1'b1;
        step();
    endtask

    task automatic take_char();
        tx_pending = 1'b0;
        tx_idle    = 1'b0;
        step();
    endtask

    task automatic end_burst();
        tx_idle = 1'b1;
        step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        auto_dir_en = 1'b1; echo_sup_en = 1'b0; dly_cfg = 8'h00;
        tx_pending = 1'b0; tx_idle = 1'b1; host_rts = 1'b0; bit_tick = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
        chk("R1", "rts_out after reset", rts_out, 1'b0);
        chk("R1", "tx_start_ok after reset", tx_start_ok, 1'b0);
        chk("R1", "rx_blank after reset", rx_blank, 1'b0);
    endtask

    task automatic t_bypass();
        auto_dir_en = 1'b0;
        host_rts = 1'b1;
        step();
        chk("R2", "rts follows host high", rts_out, 1'b1);
        chk("R2", "permission in bypass", tx_start_ok, 1'b1);
        host_rts = 1'b0;
        step();
        chk("R2", "rts follows host low", rts_out, 1'b0);
        dly_cfg = 8'hF0;
        start_burst();
        chk("R2", "permission during burst, setup ignored", tx_start_ok, 1'b1);
        chk("R2", "rts still host level", rts_out, 1'b0);
        take_char(); end_burst();
        auto_dir_en = 1'b1;
        dly_cfg = 8'h00;
        step();
        chk("R2", "rts low back in auto idle", rts_out, 1'b0);
    endtask

    task automatic t_setup(input int n);
        dly_cfg = 8'((n & 15) << 4);
        start_burst();
        chk("R3", "rts rises one cycle after pending", rts_out, 1'b1);
        chk("R3", "no permission at setup start", tx_start_ok, 1'b0);
        for (int i = 1; i < n; i++) begin
            tick();
            step();
            chk("R3", "no permission before last setup tick", tx_start_ok, 1'b0);
        end
        tick();
        chk("R3", "permission after last setup tick", tx_start_ok, 1'b1);
        chk("R3", "rts high with permission", rts_out, 1'b1);
        take_char(); end_burst();
        chk("R6", "rts low with zero hold", rts_out, 1'b0);
    endtask

    task automatic t_setup_zero();
        dly_cfg = 8'h00;
        start_burst();
        chk("R4", "rts on first cycle", rts_out, 1'b1);
        chk("R4", "permission on same cycle", tx_start_ok, 1'b1);
        take_char(); end_burst();
    endtask

    task automatic t_hold(input int m, input logic echo);
        echo_sup_en = echo;
        dly_cfg = 8'(m & 15);
        start_burst();
        chk(echo ? "R8" : "R9", "blank while active", rx_blank, echo);
        take_char();
        step();
        end_burst();
        chk("R5", "rts held at hold start", rts_out, 1'b1);
        chk("R5", "no permission in hold", tx_start_ok, 1'b0);
        chk(echo ? "R8" : "R9", "blank at hold start", rx_blank, echo);
        for (int i = 1; i < m; i++) begin
            tick();
            step();
            chk("R5", "rts held before last hold tick", rts_out, 1'b1);
            chk(echo ? "R8" : "R9", "blank before last hold tick", rx_blank, echo);
        end
        tick();
        chk("R5", "rts low after last hold tick", rts_out, 1'b0);
        chk(echo ? "R8" : "R9", "blank cleared after hold", rx_blank, 1'b0);
        echo_sup_en = 1'b0;
    endtask

    task automatic t_hold_zero();
        dly_cfg = 8'h00;
        start_burst();
        take_char();
        chk("R6", "rts high while sending", rts_out, 1'b1);
        end_burst();
        chk("R6", "rts low right after end", rts_out, 1'b0);
    endtask

    task automatic t_resume();
        dly_cfg = 8'h24;
        start_burst();
        tick(); tick();
        chk("R3", "permission after 2 setup ticks", tx_start_ok, 1'b1);
        take_char(); end_burst();
        tick();
        chk("R7", "still in hold", tx_start_ok, 1'b0);
        chk("R7", "rts high in hold", rts_out, 1'b1);
        tx_pending = 1'b1;
        step();
        chk("R7", "permission at once on resume", tx_start_ok, 1'b1);
        chk("R7", "rts never dropped", rts_out, 1'b1);
        take_char(); end_burst();
        for (int i = 0; i < 4; i++) tick();
        chk("R7", "rts low after full hold", rts_out, 1'b0);
    endtask

    task automatic t_stray();
        dly_cfg = 8'h33;
        for (int i = 0; i < 5; i++) tick();
        start_burst();
        tick(); tick();
        chk("R10", "idle ticks do not shorten setup", tx_start_ok, 1'b0);
        tick();
        chk("R10", "setup ends on its own third tick", tx_start_ok, 1'b1);
        tick(); tick(); tick(); tick();
        take_char(); end_burst();
        tick(); tick();
        chk("R10", "active ticks do not shorten hold", rts_out, 1'b1);
        tick();
        chk("R10", "hold ends on its own third tick", rts_out, 1'b0);
    endtask

    task automatic t_echo_bypass();
        auto_dir_en = 1'b0;
        echo_sup_en = 1'b1;
        host_rts = 1'b0;
        dly_cfg = 8'h52;
        start_burst();
        chk("R8", "blank in bypass burst", rx_blank, 1'b1);
        chk("R2", "rts stays host level", rts_out, 1'b0);
        take_char(); end_burst();
        tick();
        chk("R8", "blank during bypass hold", rx_blank, 1'b1);
        tick();
        chk("R8", "blank cleared after bypass hold", rx_blank, 1'b0);
        auto_dir_en = 1'b1;
        echo_sup_en = 1'b0;
        step();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_bypass();
        t_setup(1);
        t_setup(5);
        t_setup(15);
        t_setup_zero();
        t_hold(1, 1'b0);
        t_hold(6, 1'b1);
        t_hold(15, 1'b0);
        t_hold_zero();
        t_resume();
        t_stray();
        t_echo_bypass();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule